// File: doc/BRIEF.md
# Atomic Execution Location Predictor

This block sits beside an L1 data cache. For every atomic request it decides whether the read-modify-write should run in the local L1 or be sent outward to a shared cache level. The choice rests on a short history kept per cache block. A small table is indexed by a hash of the block address. Each entry records which CPU last issued an atomic to that block and how many times in a row that CPU has done so. A block that one CPU hammers without interruption is worth pulling into the L1. A block that CPUs take turns on is better served at the shared level, where no cache line has to move between cores.

A request is presented for one cycle with its block address and CPU number. The decision appears on the registered outputs in the following cycle, and the table entry is rewritten at the same clock edge. A second request to the same entry in the next cycle therefore sees the updated history. The block does not perform the atomic, send coherence traffic or hold cache data.

Top module: `atp_predictor`

## Requirements
- R1: While reset is held, `dec_valid` and `dec_local` are 0. After reset every table entry has no owner, so the first request to any block is routed outward (`dec_local` = 0).
- R2: `dec_valid` is 1 in exactly the cycle after a cycle with `req_valid` = 1, and 0 after a cycle with `req_valid` = 0.
- R3: The streak of an entry is the number of consecutive requests to it from the same CPU, counting the current one. A request is routed local (`dec_local` = 1) exactly when its streak is greater than `LIMIT` (default 4). With the default, the fifth and later consecutive requests go local.
- R4: A request from a CPU other than the recorded owner, or to an entry with no owner, is routed outward. That CPU becomes the owner and the streak restarts at 1.
- R5: The streak counter is `CNT_W` bits (default 3) and saturates at 7. It never wraps, so an uninterrupted run of any length stays local once it has passed the limit.
- R6: The entry index is the XOR of all `log2(ENTRIES)`-bit slices of `req_addr`, starting at bit 0, with the top slice zero-padded. With the defaults this is bits [5:0] ^ [11:6] ^ [17:12] ^ [23:18] ^ [29:24] ^ {4'b0, [31:30]}. Addresses with equal indices share history, and addresses with different indices do not affect each other.
- R7: Asserting `rst_n` in the middle of operation clears all history, so the next request to any block is routed outward with a streak of 1.
- R8: Cycles with `req_valid` = 0 leave the table unchanged, whatever values `req_addr` and `req_cpu` carry.
- R9: `dec_local` is 0 in every cycle where `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronised inside the block. |
| req_valid | input | 1 | Atomic request present this cycle |
| req_addr | input | ADDR_W (32) | Cache-block address of the request |
| req_cpu | input | CPU_W (4) | Number of the requesting CPU |
| dec_valid | output | 1 | A decision is present, one cycle after the request |
| dec_local | output | 1 | 1: run in the local L1; 0: send to the outer level |

## Verification
The situation hardest to reach from the ports is a long unbroken run. A local decision needs five requests in a row from one CPU to one index. Saturation needs more than seven. Any request from another CPU to an aliasing address breaks the run. Uniform random traffic almost never builds such runs. The stimulus therefore repeats the previous request with high probability, draws from a small pool of addresses and CPUs, and scatters idle cycles with junk address values between requests. Directed runs cover saturation, aliasing addresses that share an entry, and a reset taken during a streak.

// File: rtl/atp_pkg.sv
package atp_pkg;

  // Destination chosen for one atomic request.
  typedef enum logic {
    ROUTE_OUTER = 1'b0,
    ROUTE_LOCAL = 1'b1
  } route_e;

endpackage

// File: rtl/atp_rst_sync.sv
// Asserts asynchronously and releases after two clock edges.
module atp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_out = stage2_q;

endmodule

// File: rtl/atp_index_hash.sv
// XOR-folds the whole block address into an IDX_W-bit table index.
module atp_index_hash #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);

  localparam int FOLDS = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W = FOLDS * IDX_W;

  logic [PAD_W-1:0]            padded;
  logic [FOLDS:0][IDX_W-1:0]   acc;

  assign padded = PAD_W'(addr);
  assign acc[0] = '0;

  for (genvar f = 0; f < FOLDS; f++) begin : g_fold
    assign acc[f+1] = acc[f] ^ padded[f*IDX_W +: IDX_W];
  end

  assign idx = acc[FOLDS];

endmodule

// File: rtl/atp_entry_next.sv
// Next history value and routing choice for one looked-up entry.
module atp_entry_next
  import atp_pkg::*;
#(
  parameter int CPU_W = 4,
  parameter int CNT_W = 3,
  parameter int LIMIT = 4
) (
  input  logic             cur_owned,
  input  logic [CPU_W-1:0] cur_cpu,
  input  logic [CNT_W-1:0] cur_cnt,
  input  logic [CPU_W-1:0] req_cpu,
  output logic [CNT_W-1:0] nxt_cnt,
  output route_e           route
);

  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(LIMIT);

  logic streak;

  always_comb begin
    streak = cur_owned && (cur_cpu == req_cpu);
    if (!streak) begin
      nxt_cnt = CNT_ONE;
    end else if (cur_cnt == CNT_MAX) begin
      nxt_cnt = CNT_MAX;
    end else begin
      nxt_cnt = cur_cnt + CNT_ONE;
    end
    route = (nxt_cnt > CNT_LIMIT) ? ROUTE_LOCAL : ROUTE_OUTER;
  end

endmodule

// File: rtl/atp_table.sv
// Flop-based history table: owner flag, owner CPU and streak count per entry.
module atp_table #(
  parameter int ENTRIES = 64,
  parameter int CPU_W   = 4,
  parameter int CNT_W   = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             rd_owned,
  output logic [CPU_W-1:0] rd_cpu,
  output logic [CNT_W-1:0] rd_cnt,
  input  logic             wr_en,
  input  logic [CPU_W-1:0] wr_cpu,
  input  logic [CNT_W-1:0] wr_cnt
);

  logic [ENTRIES-1:0]            own_all;
  logic [ENTRIES-1:0][CPU_W-1:0] cpu_all;
  logic [ENTRIES-1:0][CNT_W-1:0] cnt_all;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic             own_q;
    logic [CPU_W-1:0] cpu_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ent_en;

    assign ent_en = wr_en && (idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_q <= 1'b0;
        cpu_q <= '0;
        cnt_q <= '0;
      end else if (ent_en) begin
        own_q <= 1'b1;
        cpu_q <= wr_cpu;
        cnt_q <= wr_cnt;
      end
    end

    assign own_all[e] = own_q;
    assign cpu_all[e] = cpu_q;
    assign cnt_all[e] = cnt_q;
  end

  assign rd_owned = own_all[idx];
  assign rd_cpu   = cpu_all[idx];
  assign rd_cnt   = cnt_all[idx];

  AST_IDLE_TABLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(own_all) && $stable(cpu_all) && $stable(cnt_all))); // R8

  AST_WRITTEN_ENTRY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (own_all[$past(idx)] && (cnt_all[$past(idx)] != '0))); // R4

endmodule

// File: rtl/atp_predictor.sv
module atp_predictor
  import atp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CPU_W   = 4,
  parameter int ENTRIES = 64,
  parameter int CNT_W   = 3,
  parameter int LIMIT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CPU_W-1:0]  req_cpu,
  output logic              dec_valid,
  output logic              dec_local
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             rst_sync_n;
  logic [IDX_W-1:0] idx;
  logic             rd_owned;
  logic [CPU_W-1:0] rd_cpu;
  logic [CNT_W-1:0] rd_cnt;
  logic [CNT_W-1:0] nxt_cnt;
  route_e           route;

  logic dec_valid_d, dec_valid_q;
  logic dec_local_d, dec_local_q;

  atp_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  atp_index_hash #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_hash (
    .addr (req_addr),
    .idx  (idx)
  );

  atp_table #(
    .ENTRIES (ENTRIES),
    .CPU_W   (CPU_W),
    .CNT_W   (CNT_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .idx      (idx),
    .rd_owned (rd_owned),
    .rd_cpu   (rd_cpu),
    .rd_cnt   (rd_cnt),
    .wr_en    (req_valid),
    .wr_cpu   (req_cpu),
    .wr_cnt   (nxt_cnt)
  );

  atp_entry_next #(
    .CPU_W (CPU_W),
    .CNT_W (CNT_W),
    .LIMIT (LIMIT)
  ) u_next (
    .cur_owned (rd_owned),
    .cur_cpu   (rd_cpu),
    .cur_cnt   (rd_cnt),
    .req_cpu   (req_cpu),
    .nxt_cnt   (nxt_cnt),
    .route     (route)
  );

  // Next-state logic for the decision outputs.
  always_comb begin
    dec_valid_d = req_valid;
    dec_local_d = req_valid && (route == ROUTE_LOCAL);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dec_valid_q <= 1'b0;
      dec_local_q <= 1'b0;
    end else begin
      dec_valid_q <= dec_valid_d;
      dec_local_q <= dec_local_d;
    end
  end

  assign dec_valid = dec_valid_q;
  assign dec_local = dec_local_q;

  AST_REQ_GETS_DECISION: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> dec_valid); // R2

  AST_IDLE_NO_DECISION: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !dec_valid); // R2

  AST_LOCAL_ONLY_WITH_DECISION: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dec_local |-> dec_valid); // R9

  AST_MISS_RESTARTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && (!rd_owned || (rd_cpu != req_cpu))) |=> (dec_valid && !dec_local)); // R4

  AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && rd_owned && (rd_cpu == req_cpu) && (rd_cnt == CNT_MAX))
      |-> (nxt_cnt == CNT_MAX)); // R5

endmodule

// File: tb/tb_atp_predictor.sv
module tb_atp_predictor;

  localparam int ADDR_W  = 32;
  localparam int CPU_W   = 4;
  localparam int ENTRIES = 64;
  localparam int IDX_W   = 6;
  localparam int LIMIT   = 4;
  localparam int CNT_SAT = 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [CPU_W-1:0]  req_cpu;
  logic              dec_valid;
  logic              dec_local;

  always #4 clk = ~clk;

  atp_predictor dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_cpu   (req_cpu),
    .dec_valid (dec_valid),
    .dec_local (dec_local)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    m_own [ENTRIES];
  int    m_cpu [ENTRIES];
  int    m_cnt [ENTRIES];
  bit    exp_v = 1'b0;
  bit    exp_l = 1'b0;
  string exp_tag = "R3";

  function automatic int hash_idx(logic [ADDR_W-1:0] a);
    int r = 0;
    for (int k = 0; k < ADDR_W; k += IDX_W) r ^= int'((a >> k) & (ENTRIES - 1));
    return r;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < ENTRIES; i++) begin
      m_own[i] = 1'b0;
      m_cpu[i] = 0;
      m_cnt[i] = 0;
    end
  endtask

  // Checks the decision of the previous cycle, then drives the next one.
  task automatic step(bit v, logic [ADDR_W-1:0] a, logic [CPU_W-1:0] c, string tag);
    @(negedge clk);
    check("R2", dec_valid, exp_v);
    if (exp_v) check(exp_tag, dec_local, exp_l);
    else       check("R9", dec_local, 1'b0);
    req_valid = v;
    req_addr  = a;
    req_cpu   = c;
    if (v) begin
      int  i = hash_idx(a);
      bit  same = m_own[i] && (m_cpu[i] == int'(c));
      m_cnt[i] = same ? ((m_cnt[i] + 1 > CNT_SAT) ? CNT_SAT : m_cnt[i] + 1) : 1;
      m_own[i] = 1'b1;
      m_cpu[i] = int'(c);
      exp_l    = (m_cnt[i] > LIMIT);
      exp_v    = 1'b1;
      exp_tag  = tag;
    end else begin
      exp_v = 1'b0;
      exp_l = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", dec_valid, 1'b0);
    check("R1", dec_local, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_clear();
    exp_v = 1'b0;
    exp_l = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] pool [8];
    logic [ADDR_W-1:0] last_a;
    logic [CPU_W-1:0]  last_c;
    void'($urandom(32'd2024));
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_cpu   = '0;
    model_clear();
    do_reset();

    // R1: first touch goes outward; R3: run from one CPU; R5: saturation.
    step(1'b1, 32'h0000_0005, 4'd1, "R1");
    for (int k = 2; k <= 12; k++)
      step(1'b1, 32'h0000_0005, 4'd1, (k > CNT_SAT) ? "R5" : "R3");

    // R4: another CPU breaks the run; the new run needs its own five hits.
    step(1'b1, 32'h0000_0005, 4'd2, "R4");
    for (int k = 2; k <= 6; k++) step(1'b1, 32'h0000_0005, 4'd2, "R4");

    // R8: idle cycles with junk inputs leave the run intact.
    step(1'b1, 32'h0000_0a00, 4'd3, "R3");
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 32'h0000_0a00, 4'd9, "R8");
      step(1'b1, 32'h0000_0a00, 4'd3, "R8");
    end

    // R6: 0x44 aliases 0x05 (4 ^ 1 = 5); 0x06 is a separate entry.
    step(1'b1, 32'h0000_0044, 4'd2, "R6");
    step(1'b1, 32'h0000_0006, 4'd2, "R6");
    step(1'b1, 32'h0000_0044, 4'd7, "R6");
    step(1'b1, 32'h0000_0005, 4'd7, "R6");

    // R7: reset during a long run clears the history.
    for (int k = 0; k < 6; k++) step(1'b1, 32'h1234_5678, 4'd4, "R3");
    step(1'b0, '0, '0, "R8");
    step(1'b0, '0, '0, "R8");
    do_reset();
    step(1'b1, 32'h1234_5678, 4'd4, "R7");
    step(1'b1, 32'h1234_5678, 4'd4, "R7");

    // Biased random traffic: long repeats, small pools, idle gaps.
    for (int p = 0; p < 8; p++) pool[p] = $urandom();
    pool[7] = pool[0] ^ 32'h0000_1041;
    last_a = pool[0];
    last_c = 4'd1;
    for (int n = 0; n < 4000; n++) begin
      bit v = ($urandom_range(99) < 85);
      if (v && ($urandom_range(99) >= 65)) begin
        last_a = pool[$urandom_range(7)];
        last_c = CPU_W'($urandom_range(2));
      end
      step(v, v ? last_a : $urandom(), v ? last_c : CPU_W'($urandom()), "R3");
    end
    step(1'b0, '0, '0, "R2");
    step(1'b0, '0, '0, "R2");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule